// File: doc/BRIEF.md
# Trim Pulse Charge Controller

This block schedules the correction pulses that nudge one converter output toward its target voltage. A charge pump outside the block pushes a short burst of current into, or pulls it out of, a hold capacitor; this controller decides when each burst starts, how long it lasts, which way it flows and how strong it is. Timing is counted from a 1 µs tick. Every 1700 ticks a new correction period begins, and a pulse 5 ticks wide is issued at its start.

A channel starts in tracking mode. In this mode its trim drive is off, so the capacitor follows the pin voltage and control can be handed over without a step. An activate strobe on an enabled channel starts active trimming. The direction is taken from a comparator flag at the start of each period. An optional fast mode selects ten-times magnitude until the supply is judged to be at its target. The target counts as reached when the comparator flag changes polarity from one period to the next. Removing the enable returns the channel to tracking on the next clock.

Top module: `trim_pulse_top`

## Requirements
- R1: While active, a new period starts every PERIOD_TICKS (default 1700) ticks of `usTick`, and each period begins with a pulse.
- R2: Each pulse stays high for exactly PULSE_TICKS (default 5) ticks. It rises on the clock edge that starts the period and falls on the edge that takes the fifth tick.
- R3: `aboveTarget` is sampled on the edge that starts a period. A value of 1 gives a sink pulse and a value of 0 gives a source pulse. The choice holds for the whole pulse, even if `aboveTarget` changes during it.
- R4: `srcPulse` and `sinkPulse` are never high together.
- R5: An `activate` strobe while `chanEn` is high and the channel is tracking makes the channel active on the next edge. That same edge starts the first period and its pulse. `activate` has no effect while the channel is already active, and none while `chanEn` is low.
- R6: While tracking, `driveEn` is low and no pulse is issued. While active, `driveEn` is high.
- R7: `fastMag` is high only when the channel is active, `speedUpSel` is high and `atTarget` is low.
- R8: `atTarget` is set at a period start where the sampled `aboveTarget` differs from the value sampled at the previous period start. It then stays set until the channel leaves active mode.
- R9: When `chanEn` is low at a clock edge, the channel is tracking after that edge. Any pulse in progress stops, and `atTarget` is cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| usTick | input | 1 | One-cycle strobe, once per microsecond |
| chanEn | input | 1 | Channel enable for the trim function |
| speedUpSel | input | 1 | Selects 10x magnitude until target is reached |
| activate | input | 1 | Strobe that starts active trimming |
| aboveTarget | input | 1 | Comparator flag: 1 = supply is above target |
| srcPulse | output | 1 | Source-current pulse strobe |
| sinkPulse | output | 1 | Sink-current pulse strobe |
| fastMag | output | 1 | 1 = 10x magnitude, 0 = 1x |
| driveEn | output | 1 | Trim output drive enable (low = high impedance) |
| atTarget | output | 1 | Supply has reached its target |

## Verification
Target detection and the next correction pulse fall on the same clock edge. That one edge sets `atTarget`, drops `fastMag` and starts a pulse in the new direction. The bench provokes this by flipping `aboveTarget` in the middle of a period while fast mode is on. A behavioural reference model checks every output on every clock, so each of these changes is judged at its exact cycle. A second collision puts an enable drop in the middle of a pulse, next to a re-activation on the very next cycle.

// File: rtl/trim_pkg.sv
package trim_pkg;
  typedef struct packed {
    logic run;
    logic restart;
  } trimCtl_t;
endpackage

// File: rtl/trim_pulse_dp.sv
module trim_pulse_dp
  import trim_pkg::*;
#(
  parameter int PERIOD_TICKS = 1700,
  parameter int PULSE_TICKS  = 5
) (
  input  logic     clk,
  input  logic     rstN,
  input  logic     usTick,
  input  trimCtl_t ctl,
  output logic     periodStart,
  output logic     pulseOn
);
  localparam int PW = $clog2(PERIOD_TICKS);
  localparam int LW = $clog2(PULSE_TICKS + 1);
  localparam logic [PW-1:0] LAST = PW'(PERIOD_TICKS - 1);
  localparam logic [LW-1:0] FULL = LW'(PULSE_TICKS);

  logic [PW-1:0] periodCnt;
  logic [LW-1:0] pulseCnt;
  logic wrap;

  assign wrap        = ctl.run && usTick && (periodCnt == LAST);
  assign periodStart = ctl.restart || wrap;
  assign pulseOn     = (pulseCnt != '0);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      periodCnt <= '0;
      pulseCnt  <= '0;
    end else if (ctl.restart) begin
      periodCnt <= '0;
      pulseCnt  <= FULL;
    end else if (!ctl.run) begin
      periodCnt <= '0;
      pulseCnt  <= '0;
    end else if (usTick) begin
      if (periodCnt == LAST) begin
        periodCnt <= '0;
        pulseCnt  <= FULL;
      end else begin
        periodCnt <= periodCnt + 1'b1;
        if (pulseCnt != '0) pulseCnt <= pulseCnt - 1'b1;
      end
    end
  end

  a_r2_width_bound: assert property (@(posedge clk) disable iff (!rstN)
    pulseCnt <= FULL);
  a_r2_no_tick_hold: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.run && !usTick && !ctl.restart) |=> $stable(pulseCnt));
  a_r9_cleared: assert property (@(posedge clk) disable iff (!rstN)
    (!ctl.run && !ctl.restart) |=> !pulseOn);
endmodule

// File: rtl/trim_pulse_ctl.sv
module trim_pulse_ctl
  import trim_pkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  logic     chanEn,
  input  logic     activate,
  input  logic     speedUpSel,
  input  logic     aboveTarget,
  input  logic     periodStart,
  input  logic     pulseOn,
  output trimCtl_t ctl,
  output logic     srcPulse,
  output logic     sinkPulse,
  output logic     fastMag,
  output logic     driveEn,
  output logic     atTarget
);
  logic activeQ;
  logic dirSink;
  logic hitQ;

  assign ctl.restart = !activeQ && chanEn && activate;
  assign ctl.run     = activeQ && chanEn;

  always_ff @(posedge clk) begin
    if (!rstN || !chanEn) begin
      activeQ <= 1'b0;
      dirSink <= 1'b0;
      hitQ    <= 1'b0;
    end else if (ctl.restart) begin
      activeQ <= 1'b1;
      dirSink <= aboveTarget;
      hitQ    <= 1'b0;
    end else if (activeQ && periodStart) begin
      dirSink <= aboveTarget;
      if (dirSink != aboveTarget) hitQ <= 1'b1;
    end
  end

  assign driveEn   = activeQ;
  assign srcPulse  = activeQ && pulseOn && !dirSink;
  assign sinkPulse = activeQ && pulseOn && dirSink;
  assign fastMag   = activeQ && speedUpSel && !hitQ;
  assign atTarget  = hitQ;

  a_r3_dir_held: assert property (@(posedge clk) disable iff (!rstN)
    (pulseOn && !periodStart && chanEn) |=> $stable(dirSink));
  a_r8_sticky: assert property (@(posedge clk) disable iff (!rstN)
    (hitQ && chanEn) |=> hitQ);
  a_r9_drop: assert property (@(posedge clk) disable iff (!rstN)
    !chanEn |=> (!driveEn && !srcPulse && !sinkPulse && !atTarget));
  a_r5_start: assert property (@(posedge clk) disable iff (!rstN)
    ctl.restart |=> (driveEn && pulseOn));
endmodule

// File: rtl/trim_pulse_top.sv
module trim_pulse_top
  import trim_pkg::*;
#(
  parameter int PERIOD_TICKS = 1700,
  parameter int PULSE_TICKS  = 5
) (
  input  logic clk,
  input  logic rstN,
  input  logic usTick,
  input  logic chanEn,
  input  logic speedUpSel,
  input  logic activate,
  input  logic aboveTarget,
  output logic srcPulse,
  output logic sinkPulse,
  output logic fastMag,
  output logic driveEn,
  output logic atTarget
);
  trimCtl_t ctl;
  logic periodStart;
  logic pulseOn;

  trim_pulse_dp #(.PERIOD_TICKS(PERIOD_TICKS), .PULSE_TICKS(PULSE_TICKS)) uDp (
    .clk(clk), .rstN(rstN), .usTick(usTick), .ctl(ctl),
    .periodStart(periodStart), .pulseOn(pulseOn));

  trim_pulse_ctl uCtl (
    .clk(clk), .rstN(rstN), .chanEn(chanEn), .activate(activate),
    .speedUpSel(speedUpSel), .aboveTarget(aboveTarget),
    .periodStart(periodStart), .pulseOn(pulseOn), .ctl(ctl),
    .srcPulse(srcPulse), .sinkPulse(sinkPulse), .fastMag(fastMag),
    .driveEn(driveEn), .atTarget(atTarget));

  a_r4_exclusive: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({srcPulse, sinkPulse}));
  a_r6_tristate: assert property (@(posedge clk) disable iff (!rstN)
    !driveEn |-> (!srcPulse && !sinkPulse));
  a_r7_fast_gate: assert property (@(posedge clk) disable iff (!rstN)
    fastMag |-> (driveEn && !atTarget));
endmodule

// File: tb/sim_trim_pulse_top.sv
module sim_trim_pulse_top;
  localparam int PER = 1700;
  localparam int PUL = 5;

  logic clk = 0, rstN = 0, usTick = 0, chanEn = 0, speedUpSel = 0, activate = 0, aboveTarget = 0;
  logic srcPulse, sinkPulse, fastMag, driveEn, atTarget;
  int checks = 0, errors = 0, cyc = 0, divCnt = 0;
  bit done = 0;

  always #4 clk = ~clk;

  trim_pulse_top u0 (
    .clk(clk), .rstN(rstN), .usTick(usTick), .chanEn(chanEn), .speedUpSel(speedUpSel),
    .activate(activate), .aboveTarget(aboveTarget), .srcPulse(srcPulse),
    .sinkPulse(sinkPulse), .fastMag(fastMag), .driveEn(driveEn), .atTarget(atTarget));

  // Behavioural reference model
  bit mAct = 0, mDir = 0, mAt = 0;
  int mPer = 0, mLeft = 0;
  always @(posedge clk) begin
    if (!rstN || !chanEn) begin
      mAct = 0; mPer = 0; mLeft = 0; mDir = 0; mAt = 0;
    end else if (!mAct && activate) begin
      mAct = 1; mPer = 0; mLeft = PUL; mDir = aboveTarget; mAt = 0;
    end else if (mAct && usTick) begin
      if (mPer == PER - 1) begin
        mPer = 0; mLeft = PUL;
        if (mDir != aboveTarget) mAt = 1;
        mDir = aboveTarget;
      end else begin
        mPer++;
        if (mLeft > 0) mLeft--;
      end
    end
  end

  task automatic chk(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s at cycle %0d: actual %b expected %b", req, cyc, act, exp);
    end
  endtask

  task automatic chkInt(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s at cycle %0d: actual %0d expected %0d", req, cyc, act, exp);
    end
  endtask

  // Per-clock comparison against the model
  always @(negedge clk) begin
    cyc++;
    if (rstN && !done) begin
      chk("R3 srcPulse", srcPulse, mAct && mLeft > 0 && !mDir);
      chk("R3 sinkPulse", sinkPulse, mAct && mLeft > 0 && mDir);
      chk("R6 driveEn", driveEn, mAct);
      chk("R7 fastMag", fastMag, mAct && speedUpSel && !mAt);
      chk("R8 atTarget", atTarget, mAt);
      if (srcPulse && sinkPulse) chk("R4 exclusive", 1'b1, 1'b0);
    end
  end

  // Tick source: one tick every two clocks
  always @(negedge clk) begin
    divCnt <= (divCnt + 1) % 2;
    usTick <= (divCnt == 1);
  end

  // Width and spacing monitor (R1, R2)
  int wTicks = 0, pTicks = 0;
  bit prevOn = 0, havePrev = 0;
  always @(negedge clk) begin
    logic on;
    on = srcPulse | sinkPulse;
    if (!driveEn || !chanEn) begin
      havePrev = 0; wTicks = 0; pTicks = 0;
    end else begin
      if (on && !prevOn) begin
        if (havePrev) chkInt("R1 period ticks", pTicks, PER);
        havePrev = 1; pTicks = 0; wTicks = 0;
      end
      if (!on && prevOn) chkInt("R2 pulse ticks", wTicks, PUL);
      if (usTick) begin
        pTicks++;
        if (on) wTicks++;
      end
    end
    prevOn = on && driveEn && chanEn;
  end

  task automatic waitClk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic strobe();
    activate = 1; @(negedge clk); activate = 0;
  endtask

  initial begin
    waitClk(4);
    chk("R6 reset driveEn", driveEn, 1'b0);
    chk("R6 reset pulses", srcPulse | sinkPulse, 1'b0);
    chk("R8 reset atTarget", atTarget, 1'b0);
    rstN = 1;
    waitClk(3);
    // R5: activate with enable low is ignored
    strobe();
    chk("R5 ignored without enable", driveEn, 1'b0);
    // R5: start, fast mode, source direction
    chanEn = 1; speedUpSel = 1; aboveTarget = 0;
    strobe();
    chk("R5 active after strobe", driveEn, 1'b1);
    chk("R3 first pulse source", srcPulse, 1'b1);
    waitClk(2);
    aboveTarget = 1; // R3: change during pulse must not flip direction
    waitClk(3);
    chk("R3 held during pulse", srcPulse, 1'b1);
    aboveTarget = 0;
    waitClk(2 * PER * 2);
    chk("R7 fast before target", fastMag, 1'b1);
    // R5: activate while active is ignored
    strobe();
    // R8: flip comparator mid-period, next start sets atTarget and ends 10x
    waitClk(PER);
    aboveTarget = 1;
    waitClk(2 * PER + 4);
    chk("R8 atTarget set", atTarget, 1'b1);
    chk("R7 fast off at target", fastMag, 1'b0);
    waitClk(2 * PER * 2);
    // R9: drop enable during a pulse
    while (!(srcPulse | sinkPulse)) waitClk(1);
    waitClk(2);
    chanEn = 0;
    waitClk(1);
    chk("R9 drive off", driveEn, 1'b0);
    chk("R9 pulse aborted", sinkPulse, 1'b0);
    chk("R9 atTarget cleared", atTarget, 1'b0);
    // R9/R5: re-enable and activate on the next cycle, slow mode
    chanEn = 1; speedUpSel = 0; aboveTarget = 1;
    strobe();
    chk("R5 restart sink", sinkPulse, 1'b1);
    chk("R7 slow mode", fastMag, 1'b0);
    waitClk(2 * PER * 2 + 20);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    waitClk(150000);
    errors++;
    $display("FAIL watchdog expired: actual running expected finished");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule